// File: doc/BRIEF.md
# Bit-Serial CORDIC Sine/Cosine Generator

This block turns a running phase into sine and cosine samples using one CORDIC rotation stage. The stage is reused over many clock cycles instead of being copied into a pipeline. A frequency word is added to an internal phase accumulator once per sample. The phase is folded into the right half-plane with its two top bits. Then `MAG_W` shift-and-add micro-rotations run, one per enabled clock, so a new sine/cosine pair comes out every `MAG_W` cycles. The rotation vector starts at the inverse of the CORDIC gain, so no output multiplier is needed. The result is rounded and clamped to a symmetric `MAG_W`-bit two's-complement range.

A sequencer steps through four named states: `ST_IDLE`, `ST_ARM`, `ST_WARM` and `ST_RUN`. The first enabled edge after reset moves `ST_IDLE` to `ST_ARM`. `ST_ARM` loads the folded phase 0, advances the accumulator and moves to `ST_WARM`. `ST_WARM` runs one full rotation pass whose result is withheld. On that pass's last iteration it loads the next phase and moves to `ST_RUN`. `ST_RUN` stays in `ST_RUN`: on each last iteration it emits a sample and loads the next phase in the same cycle. The clock enable `en` freezes the whole block while low. Only reset returns the sequencer to `ST_IDLE`.

Top module: `sincos_cordic_serial`

## Requirements
- R1: While reset is asserted and right after it, `valid` is 0 and `sin_out` and `cos_out` are 0.
- R2: On a rising edge where `en` is low, nothing advances: after that edge `valid` is 0 and `sin_out`/`cos_out` keep their values. Such edges are not counted toward any latency or period, and with `en` held low after reset no strobe ever appears.
- R3: The first `valid` pulse follows the 2·MAG_W+2-th enabled rising edge after reset.
- R4: Later `valid` pulses follow every MAG_W-th enabled edge after the previous one, and each pulse is one cycle wide.
- R5: The phase is unsigned `PHASE_W` bits, with a full turn equal to 2^PHASE_W. Strobe number j (counting from 0) reports the phase (j+1)·F mod 2^PHASE_W, where F is the constant `freq_word`. The pass for phase 0 is withheld.
- R6: The outputs are two's-complement `MAG_W`-bit numbers. `sin_out` and `cos_out` are each within 6 LSB of round((2^(MAG_W-1)-1)·sin θ) and round((2^(MAG_W-1)-1)·cos θ) respectively.
- R7: The R6 accuracy holds in all four quadrants, including phases of exactly 0, a quarter, a half and three quarters of a turn.
- R8: Neither output ever takes the value -2^(MAG_W-1); results clamp to ±(2^(MAG_W-1)-1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Clock enable; low freezes the block |
| freq_word | input | PHASE_W | Phase increment added once per sample |
| sin_out | output | MAG_W | Sine sample, two's complement |
| cos_out | output | MAG_W | Cosine sample, two's complement |
| valid | output | 1 | One-cycle strobe marking a new sample |

## Verification
The first result is due after the 2·MAG_W+2-th enabled rising edge, and each later one MAG_W enabled edges after the previous result. The bench keeps a running count of edges at which `en` was high. It reads the outputs on the falling edge, so it sees the registers after the update that raised the strobe. It compares that count with the expected slot for the sample index. Stretches with `en` low are inserted on purpose. They test that such edges shift the slots without being counted, and on each of them that the outputs held.

// File: rtl/sincos_cordic_pkg.sv
package sincos_cordic_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ARM  = 2'd1,
        ST_WARM = 2'd2,
        ST_RUN  = 2'd3
    } seq_state_e;

    localparam real PI_R = 3.14159265358979323846;

    // 2^-e as a real number
    function automatic real pow2_neg(input int e);
        real r;
        r = 1.0;
        for (int k = 0; k < e; k++) r = r / 2.0;
        return r;
    endfunction

    // arctangent of 2^-i in radians, series for i >= 1
    function automatic real atan_pow2(input int i);
        real t, t2, term, acc;
        if (i == 0) return PI_R / 4.0;
        t    = pow2_neg(i);
        t2   = t * t;
        term = t;
        acc  = 0.0;
        for (int k = 0; k < 40; k++) begin
            if ((k % 2) == 0) acc = acc + term / real'(2 * k + 1);
            else              acc = acc - term / real'(2 * k + 1);
            term = term * t2;
        end
        return acc;
    endfunction

    // 1/K for a given number of micro-rotations
    function automatic real inv_gain(input int iters);
        real p, s;
        p = 1.0;
        for (int k = 0; k < iters; k++) p = p * (1.0 + pow2_neg(2 * k));
        s = p;
        for (int k = 0; k < 60; k++) s = (s + p / s) / 2.0;
        return 1.0 / s;
    endfunction

    // round(f * 2^width) for 0 <= f < 1, as an unsigned bit vector
    function automatic logic [255:0] frac_bits(input real f, input int width);
        logic [255:0] v;
        real r;
        v = '0;
        r = f + pow2_neg(width + 1);
        for (int b = width - 1; b >= 0; b--) begin
            r = r * 2.0;
            if (r >= 1.0) begin
                v[b] = 1'b1;
                r    = r - 1.0;
            end
        end
        return v;
    endfunction

endpackage

// File: rtl/sincos_atan_rom.sv
module sincos_atan_rom
    import sincos_cordic_pkg::*;
#(
    parameter int ITERS = 16,
    parameter int ANG_W = 24,
    parameter int IDX_W = 4
) (
    input  logic [IDX_W-1:0] idx,
    output logic [ANG_W-1:0] atan_code
);

    logic [ANG_W-1:0] tab [ITERS];

    // angle units: a full turn is 2^ANG_W
    for (genvar gi = 0; gi < ITERS; gi++) begin : g_entry
        localparam logic [ANG_W-1:0] CODE =
            ANG_W'(frac_bits(atan_pow2(gi) / (2.0 * PI_R), ANG_W));
        assign tab[gi] = CODE;
    end

    assign atan_code = tab[idx];

endmodule

// File: rtl/sincos_quadrant_fold.sv
module sincos_quadrant_fold
    import sincos_cordic_pkg::*;
#(
    parameter int PHASE_W = 24,
    parameter int ANG_W   = 24,
    parameter int DATA_W  = 22,
    parameter int MAG_W   = 16,
    parameter int GUARD   = 4
) (
    input  logic        [PHASE_W-1:0] phase,
    output logic signed [DATA_W-1:0]  x_seed,
    output logic signed [DATA_W-1:0]  y_seed,
    output logic signed [ANG_W-1:0]   z_seed
);

    // amplitude in internal units, then scaled by the inverse CORDIC gain
    localparam real AMP_R = (1.0 / pow2_neg(MAG_W - 1) - 1.0) * (1.0 / pow2_neg(GUARD));
    localparam logic [DATA_W-1:0] X_START =
        DATA_W'(frac_bits(inv_gain(MAG_W) * AMP_R * pow2_neg(DATA_W), DATA_W));

    logic [ANG_W-1:0] ang;
    logic             flip;

    assign ang  = ANG_W'(phase) << (ANG_W - PHASE_W);
    // second or third quadrant: rotate by half a turn and negate the start vector
    assign flip = ang[ANG_W-1] ^ ang[ANG_W-2];

    always_comb begin
        z_seed = {ang[ANG_W-1] ^ flip, ang[ANG_W-2:0]};
        x_seed = flip ? -X_START : X_START;
        y_seed = '0;
    end

endmodule

// File: rtl/sincos_micro_rotate.sv
module sincos_micro_rotate #(
    parameter int DATA_W = 22,
    parameter int ANG_W  = 24,
    parameter int IDX_W  = 4
) (
    input  logic signed [DATA_W-1:0] x_in,
    input  logic signed [DATA_W-1:0] y_in,
    input  logic signed [ANG_W-1:0]  z_in,
    input  logic        [ANG_W-1:0]  atan_code,
    input  logic        [IDX_W-1:0]  step,
    output logic signed [DATA_W-1:0] x_out,
    output logic signed [DATA_W-1:0] y_out,
    output logic signed [ANG_W-1:0]  z_out
);

    logic signed [DATA_W-1:0] x_sh, y_sh;

    assign x_sh = x_in >>> step;
    assign y_sh = y_in >>> step;

    always_comb begin
        if (!z_in[ANG_W-1]) begin
            x_out = x_in - y_sh;
            y_out = y_in + x_sh;
            z_out = z_in - $signed(atan_code);
        end else begin
            x_out = x_in + y_sh;
            y_out = y_in - x_sh;
            z_out = z_in + $signed(atan_code);
        end
    end

endmodule

// File: rtl/sincos_cordic_serial.sv
module sincos_cordic_serial
    import sincos_cordic_pkg::*;
#(
    parameter int MAG_W   = 16,
    parameter int PHASE_W = 24,
    parameter int GUARD   = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     en,
    input  logic        [PHASE_W-1:0] freq_word,
    output logic signed [MAG_W-1:0]   sin_out,
    output logic signed [MAG_W-1:0]   cos_out,
    output logic                     valid
);

    localparam int DATA_W = MAG_W + GUARD + 2;
    localparam int ANG_W  = (PHASE_W > MAG_W + 6) ? PHASE_W : MAG_W + 6;
    localparam int IDX_W  = $clog2(MAG_W);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(MAG_W - 1);
    localparam logic signed [DATA_W-1:0] LIM_D =
        {{(GUARD + 3){1'b0}}, {(MAG_W - 1){1'b1}}};
    localparam logic signed [DATA_W-1:0] HALF_D = DATA_W'(1) << (GUARD - 1);

    seq_state_e state, state_nx;
    logic load_seed, step_en, emit;

    logic        [PHASE_W-1:0] acc;
    logic        [IDX_W-1:0]   cnt;
    logic signed [DATA_W-1:0]  x_q, y_q, x_seed, y_seed, x_rot, y_rot;
    logic signed [ANG_W-1:0]   z_q, z_seed, z_rot;
    logic        [ANG_W-1:0]   atan_code;
    logic                      last;

    assign last = (cnt == LAST_IDX);

    sincos_quadrant_fold #(
        .PHASE_W(PHASE_W), .ANG_W(ANG_W), .DATA_W(DATA_W),
        .MAG_W(MAG_W), .GUARD(GUARD)
    ) u_fold (
        .phase (acc),
        .x_seed(x_seed),
        .y_seed(y_seed),
        .z_seed(z_seed)
    );

    sincos_atan_rom #(.ITERS(MAG_W), .ANG_W(ANG_W), .IDX_W(IDX_W)) u_rom (
        .idx      (cnt),
        .atan_code(atan_code)
    );

    sincos_micro_rotate #(.DATA_W(DATA_W), .ANG_W(ANG_W), .IDX_W(IDX_W)) u_rot (
        .x_in     (x_q),
        .y_in     (y_q),
        .z_in     (z_q),
        .atan_code(atan_code),
        .step     (cnt),
        .x_out    (x_rot),
        .y_out    (y_rot),
        .z_out    (z_rot)
    );

    // round away the guard bits and clamp symmetrically
    function automatic logic signed [MAG_W-1:0] to_sample(input logic signed [DATA_W-1:0] v);
        logic signed [DATA_W-1:0] r;
        r = (v + HALF_D) >>> GUARD;
        if (r > LIM_D)       r = LIM_D;
        else if (r < -LIM_D) r = -LIM_D;
        return MAG_W'(r);
    endfunction

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  state <= ST_IDLE;
        else if (en) state <= state_nx;
    end

    // next state and control outputs
    always_comb begin
        state_nx  = state;
        load_seed = 1'b0;
        step_en   = 1'b0;
        emit      = 1'b0;
        unique case (state)
            ST_IDLE: state_nx = ST_ARM;
            ST_ARM: begin
                load_seed = 1'b1;
                state_nx  = ST_WARM;
            end
            ST_WARM: begin
                if (last) begin
                    load_seed = 1'b1;
                    state_nx  = ST_RUN;
                end else begin
                    step_en = 1'b1;
                end
            end
            ST_RUN: begin
                if (last) begin
                    load_seed = 1'b1;
                    emit      = 1'b1;
                end else begin
                    step_en = 1'b1;
                end
            end
        endcase
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc     <= '0;
            cnt     <= '0;
            x_q     <= '0;
            y_q     <= '0;
            z_q     <= '0;
            sin_out <= '0;
            cos_out <= '0;
            valid   <= 1'b0;
        end else begin
            valid <= en & emit;
            if (en) begin
                if (load_seed) begin
                    x_q <= x_seed;
                    y_q <= y_seed;
                    z_q <= z_seed;
                    acc <= acc + freq_word;
                    cnt <= '0;
                end else if (step_en) begin
                    x_q <= x_rot;
                    y_q <= y_rot;
                    z_q <= z_rot;
                    cnt <= cnt + 1'b1;
                end
                if (emit) begin
                    sin_out <= to_sample(y_rot);
                    cos_out <= to_sample(x_rot);
                end
            end
        end
    end

endmodule

// File: rtl/sincos_cordic_serial_chk.sv
module sincos_cordic_serial_chk #(
    parameter int MAG_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             valid,
    input logic [MAG_W-1:0] sin_out,
    input logic [MAG_W-1:0] cos_out
);

    localparam int LAT = 2 * MAG_W + 2;
    localparam logic [MAG_W-1:0] MOST_NEG = {1'b1, {(MAG_W - 1){1'b0}}};

    int   since;
    int   gap;
    logic seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since <= 0;
            gap   <= 0;
            seen  <= 1'b0;
        end else begin
            if (en && since < LAT) since <= since + 1;
            if (valid) begin
                gap  <= en ? 1 : 0;
                seen <= 1'b1;
            end else if (en) begin
                gap <= gap + 1;
            end
        end
    end

    // R2: a disabled edge leaves the samples untouched and raises no strobe
    p_hold_when_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!valid && $stable(sin_out) && $stable(cos_out)));

    // R3: no strobe before the start-up latency has elapsed
    p_first_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> (since == LAT));

    // R4: strobes are spaced by MAG_W enabled edges
    p_sample_period_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && seen) |-> (gap == MAG_W));

    // R4: strobe lasts one cycle
    p_strobe_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);

    // R8: the asymmetric extreme code never appears
    p_no_most_neg_r8: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> (sin_out != MOST_NEG && cos_out != MOST_NEG));

endmodule

bind sincos_cordic_serial sincos_cordic_serial_chk #(.MAG_W(MAG_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (en),
    .valid  (valid),
    .sin_out(sin_out),
    .cos_out(cos_out)
);

// File: tb/sincos_cordic_serial_test.sv
module sincos_cordic_serial_test;

    localparam int N   = 16;
    localparam int PW  = 24;
    localparam int LAT = 2 * N + 2;
    localparam int TOL = 6;
    localparam real PI_R = 3.14159265358979323846;
    localparam real AMP  = 32767.0;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 en = 1'b0;
    logic        [PW-1:0] freq_word = '0;
    logic signed [N-1:0]  sin_out, cos_out;
    logic                 valid;

    int    n_checks = 0;
    int    n_fail = 0;
    int    cycles = 0;
    int    en_edges = 0;
    logic  en_prev = 1'b0;
    int    sample_k = 0;
    logic  prev_valid = 1'b0;
    logic signed [N-1:0] prev_sin = '0, prev_cos = '0;
    string cur_tag = "R6";
    logic [PW-1:0] exp_q[$];

    sincos_cordic_serial #(.MAG_W(N), .PHASE_W(PW)) uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .freq_word(freq_word),
        .sin_out  (sin_out),
        .cos_out  (cos_out),
        .valid    (valid)
    );

    always #2 clk = ~clk;

    task automatic check_int(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_near(input string req, input int act, input int exp, input int tol);
        int d;
        n_checks++;
        d = act - exp;
        if (d < 0) d = -d;
        if (d > tol) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (+/-%0d)", req, act, exp, tol);
        end
    endtask

    function automatic int rnd(input real v);
        if (v >= 0.0) return $rtoi(v + 0.5);
        return $rtoi(v - 0.5);
    endfunction

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    endtask

    // enabled-edge counter and enable history, sampled at the active edge
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_edges <= 0;
            en_prev  <= 1'b0;
        end else begin
            if (en) en_edges <= en_edges + 1;
            en_prev <= en;
        end
    end

    // watchdog
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            finish_run();
        end
    end

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst_n) begin
            sample_k = 0;
        end else begin
            if (!en_prev) begin
                // R2: held state on a disabled edge
                check_int("R2 hold valid", int'(valid), 0);
                check_int("R2 hold sin", int'(sin_out), int'(prev_sin));
                check_int("R2 hold cos", int'(cos_out), int'(prev_cos));
            end
            if (valid) begin
                check_int("R4 pulse width", int'(prev_valid), 0);
                if (exp_q.size() == 0) begin
                    check_int("R2 R3 unexpected strobe", 1, 0);
                end else begin
                    logic [PW-1:0] ph;
                    real th;
                    ph = exp_q.pop_front();
                    th = 2.0 * PI_R * real'(ph) / 16777216.0;
                    check_near({cur_tag, " sin"}, int'(sin_out), rnd(AMP * $sin(th)), TOL);
                    check_near({cur_tag, " cos"}, int'(cos_out), rnd(AMP * $cos(th)), TOL);
                    if (sample_k == 0) check_int("R3 first latency", en_edges, LAT);
                    else               check_int("R4 period", en_edges, LAT + sample_k * N);
                    check_int("R8 no most-negative",
                              int'(sin_out == -16'sd32768 || cos_out == -16'sd32768), 0);
                    sample_k++;
                end
            end
        end
        prev_valid = valid;
        prev_sin   = sin_out;
        prev_cos   = cos_out;
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        en    = 1'b0;
        exp_q.delete();
        repeat (4) @(negedge clk);
        // R1: reset state
        check_int("R1 valid", int'(valid), 0);
        check_int("R1 sin", int'(sin_out), 0);
        check_int("R1 cos", int'(cos_out), 0);
        rst_n = 1'b1;
    endtask

    // driver: push expected phases, run the enable until they drain
    task automatic run_case(input logic [PW-1:0] f, input int n, input bit gappy, input string tag);
        logic [PW-1:0] ph;
        int t;
        do_reset();
        cur_tag   = tag;
        freq_word = f;
        ph = '0;
        for (int k = 0; k < n; k++) begin
            ph = ph + f;   // R5: sample j carries phase (j+1)*F
            exp_q.push_back(ph);
        end
        t = 0;
        while (exp_q.size() > 0 && t < 20000) begin
            @(negedge clk);
            en = gappy ? ((t % 5) != 2) : 1'b1;
            t++;
        end
        @(negedge clk);
        en = 1'b0;
        check_int({tag, " samples drained"}, exp_q.size(), 0);
        exp_q.delete();
        repeat (3) @(negedge clk);
    endtask

    initial begin
        // R1 and R2: reset, then enable held low for a long time
        do_reset();
        repeat (3 * LAT) @(negedge clk);
        check_int("R2 idle valid", int'(valid), 0);
        check_int("R2 idle sin", int'(sin_out), 0);

        run_case(24'h010000, 24, 1'b0, "R5 R6");
        run_case(24'h5EB852, 40, 1'b0, "R5 R6 R7");
        run_case(24'h400000, 12, 1'b0, "R7 quarter");
        run_case(24'h200000, 16, 1'b0, "R7 eighth");
        run_case(24'h2A3D71, 30, 1'b1, "R2 R6 gapped");
        run_case(24'h000000, 6,  1'b0, "R6 zero");
        run_case(24'hFF0000, 20, 1'b1, "R5 R7 reverse");

        finish_run();
    end

endmodule